// File: doc/BRIEF.md
# Gated-Command Channel Controller with Pattern Fill

This block is a single channel of a memory engine. It holds one of three states (idle, active, paused), which can be read at any time, and four one-cycle command strobes move it between them. Each command is accepted only in the states where it is legal. A refused start while running raises a one-cycle busy pulse. Other illegal commands leave the channel as it was.

The channel has four operation modes. In fill mode it writes one 64-bit pattern, built from two 32-bit halves, to consecutive 8-byte words from a destination pointer until a byte count is covered. The writes go out in fixed-length bursts on a valid/ready write port. In the three descriptor-chain modes only two things are modelled: the alignment check on the chain pointer and the active state itself. The chain datapath is outside the block.

A start request that fails its configuration check sets a configuration-error flag and leaves the state alone. Pause and stop requests take effect at the end of the burst in flight. A pause can later be resumed from the first word not yet written.

Top module: `dma_fill_channel`

## Requirements
- R1: `ch_state` encodes idle as 0, active as 1 and paused as 2, and never shows 3. Reset (synchronous, active-low) gives idle with every pulse, flag and write output low.
- R2: A start in idle or paused with a valid configuration moves the channel to active in the next cycle. A fill started from paused reloads the pointer and count and begins again.
- R3: A pause is accepted only in active. The channel becomes paused once the burst in flight has completed, and no write is offered while paused.
- R4: A restart is accepted only in paused. It returns the channel to active, and the fill goes on at the next unwritten address, so the addresses across the pause form one unbroken sequence.
- R5: A stop in active finishes the burst in flight, then moves to idle without a done pulse. A stop in idle changes nothing and raises no flag.
- R6: A pause or restart in idle, a restart in active and a pause in paused are all ignored.
- R7: A start in active leaves the state unchanged and raises `busy_err` for exactly one cycle.
- R8: Fill mode (`op_mode` = 3) writes {`pattern_hi`,`pattern_lo`} to `dst_ptr`, `dst_ptr`+8, and so on, for ceil(`fill_bytes`/8) words. It then returns to idle and pulses `fill_done` for one cycle.
- R9: Writes are grouped in bursts of 4 beats. `mem_wr_last` marks the 4th beat of each burst and the final beat of the fill.
- R10: In fill mode the byte count must lie between 16 and 2^32-1. A count of exactly 2^32 is treated as 2^32-1 and accepted. Any other out-of-range count sets `cfg_err`, and the state does not change.
- R11: The chain pointer `desc_ptr` must have bits [5:0] clear in XOR mode (`op_mode` = 0) and bits [4:0] clear in CRC (1) or copy (2) mode. Otherwise `cfg_err` is set and the start is refused. `cfg_err` clears on the next accepted start.
- R12: In the chain modes an accepted start makes the channel active, but no write is ever offered.
- R13: While `mem_wr_ready` is low, a pending beat stays on the port with its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_pause | input | 1 | Pause strobe |
| cmd_restart | input | 1 | Restart strobe |
| op_mode | input | 2 | 0 XOR, 1 CRC, 2 copy, 3 fill |
| desc_ptr | input | 32 | Chain pointer for the chain modes |
| dst_ptr | input | 32 | First fill address |
| fill_bytes | input | 33 | Fill length in bytes |
| pattern_hi | input | 32 | Upper half of the fill word |
| pattern_lo | input | 32 | Lower half of the fill word |
| ch_state | output | 2 | Current channel state |
| busy_err | output | 1 | One-cycle pulse: start refused while active |
| cfg_err | output | 1 | Last start refused for bad configuration |
| fill_done | output | 1 | One-cycle pulse when a fill completes |
| mem_wr_valid | output | 1 | Write beat offered |
| mem_wr_ready | input | 1 | Write beat taken |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 64 | Write data |
| mem_wr_last | output | 1 | Last beat of a burst |

## Verification
The assertions assume that `mem_wr_ready` may drop at any time. They also assume the configuration inputs (mode, pointers, count, pattern) do not change while a fill is running, since the address-step and pattern properties rest on that. The stimulus changes configuration only when the channel is idle or paused. Commands are one-cycle strobes, one at a time, raised and lowered half a cycle away from the clock edge. The ready line is lowered only in one stall window, during a running fill.

// File: rtl/dma_fill_pkg.sv
// Shared state and mode encodings for the fill channel.
package dma_fill_pkg;
    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ACTIVE = 2'd1,
        CH_PAUSED = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        OP_XOR  = 2'd0,
        OP_CRC  = 2'd1,
        OP_COPY = 2'd2,
        OP_FILL = 2'd3
    } op_mode_e;
endpackage

// File: rtl/dma_cfg_check.sv
// Configuration check for a start request.
// Fill mode: range-checks the byte count (the top power of two is pulled
// down by one) and converts it to a rounded-up word count.
// Chain modes: checks the chain pointer's low-order alignment bits.
// Purely combinational. Assumes its inputs are held steady around the start strobe.
module dma_cfg_check
    import dma_fill_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              SIZE_W      = 33,
    parameter int              WB_SHIFT    = 3,
    parameter int              CNT_W       = SIZE_W + 1 - WB_SHIFT,
    parameter int              XOR_ALIGN   = 6,
    parameter int              CHAIN_ALIGN = 5,
    parameter longint unsigned MIN_BYTES   = 16,
    parameter longint unsigned MAX_BYTES   = 64'hFFFF_FFFF
) (
    input  op_mode_e          mode,
    input  logic [ADDR_W-1:0] desc_ptr,
    input  logic [SIZE_W-1:0] req_bytes,
    output logic              cfg_ok,
    output logic [CNT_W-1:0]  word_count
);
    localparam logic [SIZE_W-1:0] CLAMP_AT   = {1'b1, {(SIZE_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] XOR_MASK   = ADDR_W'((64'd1 << XOR_ALIGN) - 1);
    localparam logic [ADDR_W-1:0] CHAIN_MASK = ADDR_W'((64'd1 << CHAIN_ALIGN) - 1);
    localparam logic [SIZE_W:0]   ROUND_ADD  = (SIZE_W+1)'((1 << WB_SHIFT) - 1);

    logic [SIZE_W-1:0] eff_bytes;
    logic [SIZE_W:0]   rounded;
    logic              size_ok;

    // Pull an exact top-power-of-two request down by one byte.
    always_comb eff_bytes = (req_bytes == CLAMP_AT) ? req_bytes - 1'b1 : req_bytes;

    // Round up to whole words.
    always_comb rounded = {1'b0, eff_bytes} + ROUND_ADD;
    assign word_count = CNT_W'(rounded >> WB_SHIFT);

    // Legal byte range for fill mode.
    always_comb size_ok = (eff_bytes >= SIZE_W'(MIN_BYTES)) && (eff_bytes <= SIZE_W'(MAX_BYTES));

    // Mode-dependent acceptance.
    always_comb begin
        unique case (mode)
            OP_XOR:          cfg_ok = (desc_ptr & XOR_MASK) == '0;
            OP_CRC, OP_COPY: cfg_ok = (desc_ptr & CHAIN_MASK) == '0;
            default:         cfg_ok = size_ok;
        endcase
    end
endmodule

// File: rtl/dma_fill_engine.sv
// Fill write generator: holds the next address, the words remaining and the
// beat position inside the current burst. Offers beats while run is high,
// and latches the pattern on load. Assumes load and run are never high together.
module dma_fill_engine #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 31,
    parameter int DATA_W      = 64,
    parameter int WORD_BYTES  = 8,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_words,
    input  logic [DATA_W-1:0] load_pattern,
    input  logic              run,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              at_boundary,
    output logic              finish
);
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
    localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(BURST_BEATS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [BEAT_W-1:0] beat_q;
    logic [DATA_W-1:0] pat_q;
    logic              fire;

    // Beat offer and handshake.
    always_comb begin
        wr_valid    = run && (left_q != '0);
        fire        = wr_valid && wr_ready;
        wr_last     = (beat_q == BEAT_END) || (left_q == CNT_W'(1));
        finish      = fire && (left_q == CNT_W'(1));
        at_boundary = (beat_q == '0);
    end

    assign wr_addr = addr_q;
    assign wr_data = pat_q;

    // Counter and pattern update on load or accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            beat_q <= '0;
            pat_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            left_q <= load_words;
            beat_q <= '0;
            pat_q  <= load_pattern;
        end else if (fire) begin
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            left_q <= left_q - 1'b1;
            beat_q <= wr_last ? '0 : beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/dma_ch_ctrl.sv
// Channel state machine. Filters the command strobes by state, with the
// priority stop > pause > restart > start. Holds pause and stop requests
// until the burst boundary and produces the busy, config-error and done flags.
// Assumes the strobes are one cycle wide.
module dma_ch_ctrl
    import dma_fill_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_start,
    input  logic      cmd_stop,
    input  logic      cmd_pause,
    input  logic      cmd_restart,
    input  logic      cfg_ok,
    input  logic      req_fill,
    input  logic      at_boundary,
    input  logic      finish,
    output ch_state_e state,
    output logic      load,
    output logic      run,
    output logic      busy_err,
    output logic      cfg_err,
    output logic      done
);
    ch_state_e state_q;
    logic      pend_stop_q, pend_pause_q, fill_q;
    logic      busy_q, cfg_err_q, done_q;
    logic      stop_ok, pause_ok, restart_ok, start_try, hold;

    // Legality of each command in the present state.
    always_comb begin
        stop_ok    = cmd_stop && (state_q == CH_ACTIVE);
        pause_ok   = cmd_pause && !cmd_stop && (state_q == CH_ACTIVE) && !pend_stop_q;
        restart_ok = cmd_restart && (state_q == CH_PAUSED);
        start_try  = cmd_start && (state_q != CH_ACTIVE) && !restart_ok;
        load       = start_try && cfg_ok;
        hold       = (pend_stop_q || pend_pause_q) && at_boundary;
        run        = (state_q == CH_ACTIVE) && fill_q && !hold;
    end

    // State, pending requests and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= CH_IDLE;
            pend_stop_q  <= 1'b0;
            pend_pause_q <= 1'b0;
            fill_q       <= 1'b0;
            busy_q       <= 1'b0;
            cfg_err_q    <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            busy_q <= cmd_start && (state_q == CH_ACTIVE);
            done_q <= 1'b0;
            if (start_try && !cfg_ok) cfg_err_q <= 1'b1;
            if (load) cfg_err_q <= 1'b0;
            unique case (state_q)
                CH_ACTIVE: begin
                    if (finish) begin
                        state_q      <= CH_IDLE;
                        done_q       <= 1'b1;
                        pend_stop_q  <= 1'b0;
                        pend_pause_q <= 1'b0;
                    end else if (hold) begin
                        state_q      <= pend_stop_q ? CH_IDLE : CH_PAUSED;
                        pend_stop_q  <= 1'b0;
                        pend_pause_q <= 1'b0;
                    end else begin
                        if (stop_ok)  pend_stop_q  <= 1'b1;
                        if (pause_ok) pend_pause_q <= 1'b1;
                    end
                end
                default: begin
                    if (load) begin
                        state_q <= CH_ACTIVE;
                        fill_q  <= req_fill;
                    end else if (restart_ok) begin
                        state_q <= CH_ACTIVE;
                    end
                end
            endcase
        end
    end

    assign state    = state_q;
    assign busy_err = busy_q;
    assign cfg_err  = cfg_err_q;
    assign done     = done_q;
endmodule

// File: rtl/dma_fill_channel.sv
// Top of one memory-engine channel: command gating, configuration check
// and pattern-fill write generation. Assumes configuration inputs are
// stable from a start strobe until the channel leaves active.
module dma_fill_channel
    import dma_fill_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              SIZE_W      = 33,
    parameter int              HALF_W      = 32,
    parameter int              BURST_BEATS = 4,
    parameter longint unsigned MIN_BYTES   = 16,
    parameter longint unsigned MAX_BYTES   = 64'hFFFF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_stop,
    input  logic                cmd_pause,
    input  logic                cmd_restart,
    input  logic [1:0]          op_mode,
    input  logic [ADDR_W-1:0]   desc_ptr,
    input  logic [ADDR_W-1:0]   dst_ptr,
    input  logic [SIZE_W-1:0]   fill_bytes,
    input  logic [HALF_W-1:0]   pattern_hi,
    input  logic [HALF_W-1:0]   pattern_lo,
    output logic [1:0]          ch_state,
    output logic                busy_err,
    output logic                cfg_err,
    output logic                fill_done,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [2*HALF_W-1:0] mem_wr_data,
    output logic                mem_wr_last
);
    localparam int DATA_W     = 2 * HALF_W;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WB_SHIFT   = $clog2(WORD_BYTES);
    localparam int CNT_W      = SIZE_W + 1 - WB_SHIFT;

    op_mode_e   mode;
    ch_state_e  state;
    logic       cfg_ok, load, run, at_boundary, finish;
    logic [CNT_W-1:0] word_count;

    assign mode = op_mode_e'(op_mode);

    dma_cfg_check #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WB_SHIFT(WB_SHIFT), .CNT_W(CNT_W),
        .XOR_ALIGN(6), .CHAIN_ALIGN(5), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)
    ) u_cfg (
        .mode(mode), .desc_ptr(desc_ptr), .req_bytes(fill_bytes),
        .cfg_ok(cfg_ok), .word_count(word_count)
    );

    dma_ch_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_pause(cmd_pause), .cmd_restart(cmd_restart),
        .cfg_ok(cfg_ok), .req_fill(mode == OP_FILL),
        .at_boundary(at_boundary), .finish(finish),
        .state(state), .load(load), .run(run),
        .busy_err(busy_err), .cfg_err(cfg_err), .done(fill_done)
    );

    dma_fill_engine #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
        .WORD_BYTES(WORD_BYTES), .BURST_BEATS(BURST_BEATS)
    ) u_fill (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_addr(dst_ptr), .load_words(word_count),
        .load_pattern({pattern_hi, pattern_lo}),
        .run(run), .wr_ready(mem_wr_ready),
        .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .wr_last(mem_wr_last), .at_boundary(at_boundary), .finish(finish)
    );

    assign ch_state = state;
endmodule

// File: rtl/dma_fill_channel_chk.sv
// Property checker attached to the channel top by bind.
// Assumes a correct design, with the configuration held while the channel is active.
module dma_fill_channel_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ch_state,
    input logic              fill_done,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr
);
    a_r1_state_encoding: assert property (@(posedge clk) disable iff (!rst_n)
        ch_state != 2'd3);

    a_r3_paused_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_state == 2'd2 && $past(ch_state) != 2'd2) |-> $past(ch_state) == 2'd1);

    a_r8_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> ch_state == 2'd0);

    a_r12_write_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> ch_state == 2'd1);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ready) |=>
            (!mem_wr_valid || mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(WORD_BYTES)));

    a_r13_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> $stable(mem_wr_addr));
endmodule

bind dma_fill_channel dma_fill_channel_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(2*HALF_W/8)) u_chk (
    .clk(clk), .rst_n(rst_n), .ch_state(ch_state), .fill_done(fill_done),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr)
);

// File: tb/sim_dma_fill_channel.sv
module sim_dma_fill_channel;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] S_IDLE = 2'd0, S_ACT = 2'd1, S_PAU = 2'd2;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] ptr;
        logic [32:0] size;
        logic [1:0]  exp_state;
        logic        exp_err;
        logic [7:0]  exp_words;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd0, 32'h0000_0040, 33'd64, S_ACT, 1'b0, 8'd0},           // R11 XOR aligned
        '{2'd0, 32'h0000_0020, 33'd64, S_IDLE, 1'b1, 8'd0},          // R11 XOR misaligned
        '{2'd2, 32'h0000_0020, 33'd64, S_ACT, 1'b0, 8'd0},           // R11 copy aligned
        '{2'd1, 32'h0000_0011, 33'd64, S_IDLE, 1'b1, 8'd0},          // R11 CRC misaligned
        '{2'd3, 32'h0000_1000, 33'd40, S_ACT, 1'b0, 8'd5},           // R8 fill
        '{2'd3, 32'h0000_2000, 33'd37, S_ACT, 1'b0, 8'd5},           // R8 round up
        '{2'd3, 32'h0000_3000, 33'd8, S_IDLE, 1'b1, 8'd0},           // R10 too small
        '{2'd3, 32'h0000_4000, 33'h1_0000_0001, S_IDLE, 1'b1, 8'd0}, // R10 too large
        '{2'd3, 32'h0000_5000, 33'h1_0000_0000, S_ACT, 1'b0, 8'd0}   // R10 clamp
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start = 0, cmd_stop = 0, cmd_pause = 0, cmd_restart = 0;
    logic [1:0]  op_mode = 0;
    logic [31:0] desc_ptr = 0, dst_ptr = 0, pattern_hi = 32'hA5A5_0001, pattern_lo = 32'h5A5A_0002;
    logic [32:0] fill_bytes = 0;
    logic        mem_wr_ready = 1'b1;
    logic [1:0]  ch_state;
    logic        busy_err, cfg_err, fill_done, mem_wr_valid, mem_wr_last;
    logic [31:0] mem_wr_addr;
    logic [63:0] mem_wr_data;

    int checks = 0, errors = 0;
    longint beats = 0, exp_total = 0, done_cnt = 0;
    logic [31:0] exp_addr = 0;
    int bib = 0;

    dma_fill_channel u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_pause(cmd_pause), .cmd_restart(cmd_restart), .op_mode(op_mode),
        .desc_ptr(desc_ptr), .dst_ptr(dst_ptr), .fill_bytes(fill_bytes),
        .pattern_hi(pattern_hi), .pattern_lo(pattern_lo), .ch_state(ch_state),
        .busy_err(busy_err), .cfg_err(cfg_err), .fill_done(fill_done),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_last(mem_wr_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Beat monitor: address, data and burst-end flag (R8, R9, R4).
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            automatic bit exp_last = (bib == 3) || (exp_total - beats == 1);
            check(mem_wr_addr == exp_addr, "R8 beat address", mem_wr_addr, exp_addr);
            check(mem_wr_data == {pattern_hi, pattern_lo}, "R8 beat data", mem_wr_data, {pattern_hi, pattern_lo});
            check(mem_wr_last == exp_last, "R9 burst last", mem_wr_last, exp_last);
            beats++;
            exp_addr += 32'd8;
            bib = exp_last ? 0 : bib + 1;
        end
        if (rst_n && fill_done) done_cnt++;
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic cmd(input int c);
        case (c)
            0: cmd_start = 1; 1: cmd_stop = 1; 2: cmd_pause = 1; default: cmd_restart = 1;
        endcase
        tick(1);
        cmd_start = 0; cmd_stop = 0; cmd_pause = 0; cmd_restart = 0;
    endtask

    task automatic setup(input logic [1:0] m, input logic [31:0] p, input logic [32:0] sz, input longint tot);
        op_mode = m; desc_ptr = p; dst_ptr = p; fill_bytes = sz;
        exp_addr = p; exp_total = tot; beats = 0; bib = 0;
    endtask

    task automatic wait_state(input logic [1:0] s, input int lim);
        for (int i = 0; i < lim && ch_state != s; i++) tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint b, d0;
        logic [31:0] a;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check(ch_state == S_IDLE, "R1 reset state", ch_state, S_IDLE);
        check({busy_err, cfg_err, fill_done, mem_wr_valid} == 4'b0, "R1 reset outputs",
              {busy_err, cfg_err, fill_done, mem_wr_valid}, 0);

        // Vector table walk
        for (int i = 0; i < 9; i++) begin
            setup(VECS[i].mode, VECS[i].ptr, VECS[i].size,
                  VECS[i].exp_words != 0 ? longint'(VECS[i].exp_words) : 64'h7FFF_FFFF);
            d0 = done_cnt;
            cmd(0);
            check(ch_state == VECS[i].exp_state, "R2/R10/R11 state after start", ch_state, VECS[i].exp_state);
            check(cfg_err == VECS[i].exp_err, "R10/R11 cfg_err", cfg_err, VECS[i].exp_err);
            if (VECS[i].exp_words != 0) begin
                wait_state(S_IDLE, 60);
                check(beats == longint'(VECS[i].exp_words), "R8 word count", beats, VECS[i].exp_words);
                check(done_cnt == d0 + 1, "R8 done pulse", done_cnt - d0, 1);
            end else if (VECS[i].exp_state == S_ACT) begin
                tick(2);
                if (VECS[i].mode != 2'd3)
                    check(mem_wr_valid == 1'b0, "R12 no write in chain mode", mem_wr_valid, 0);
                cmd(1);
                wait_state(S_IDLE, 20);
                check(ch_state == S_IDLE, "R5 stop reaches idle", ch_state, S_IDLE);
            end
        end

        // R5, R6: illegal or no-op commands while idle
        cmd(2); check(ch_state == S_IDLE, "R6 pause in idle", ch_state, S_IDLE);
        cmd(3); check(ch_state == S_IDLE, "R6 restart in idle", ch_state, S_IDLE);
        cmd(1); check(ch_state == S_IDLE && !busy_err && !cfg_err, "R5 stop in idle",
                      {ch_state, busy_err, cfg_err}, 0);

        // R7 busy, R6 restart in active, R13 stall
        setup(2'd3, 32'h0000_6000, 33'd160, 20);
        d0 = done_cnt;
        cmd(0);
        cmd(0);
        check(busy_err == 1'b1 && ch_state == S_ACT, "R7 busy pulse", {busy_err, ch_state}, 3'b101);
        tick(1);
        check(busy_err == 1'b0, "R7 busy one cycle", busy_err, 0);
        cmd(3);
        check(ch_state == S_ACT, "R6 restart in active", ch_state, S_ACT);
        mem_wr_ready = 1'b0;
        tick(1);
        a = mem_wr_addr;
        tick(3);
        check(mem_wr_valid && mem_wr_addr == a, "R13 stall holds", mem_wr_addr, a);
        mem_wr_ready = 1'b1;
        wait_state(S_IDLE, 80);
        check(beats == 20 && done_cnt == d0 + 1, "R8 stalled fill complete", beats, 20);

        // R3 pause and R4 restart
        setup(2'd3, 32'h0000_8000, 33'd96, 12);
        d0 = done_cnt;
        cmd(0);
        tick(1);
        cmd(2);
        wait_state(S_PAU, 10);
        check(ch_state == S_PAU, "R3 paused", ch_state, S_PAU);
        check(beats % 4 == 0 && beats > 0 && beats < 12, "R3 pause at burst end", beats, 4);
        b = beats;
        tick(5);
        check(beats == b && !mem_wr_valid, "R3 no writes while paused", beats, b);
        cmd(2);
        check(ch_state == S_PAU, "R6 pause in paused", ch_state, S_PAU);
        cmd(3);
        check(ch_state == S_ACT, "R4 restart to active", ch_state, S_ACT);
        wait_state(S_IDLE, 40);
        check(beats == 12 && done_cnt == d0 + 1, "R4 resumed fill complete", beats, 12);

        // R5 stop mid-fill
        setup(2'd3, 32'h0000_9000, 33'd800, 100);
        d0 = done_cnt;
        cmd(0);
        tick(2);
        cmd(1);
        wait_state(S_IDLE, 20);
        check(ch_state == S_IDLE && beats % 4 == 0 && beats < 100, "R5 stop after burst", beats, 4);
        check(done_cnt == d0, "R5 no done on stop", done_cnt - d0, 0);

        // R2 start from paused reloads
        setup(2'd3, 32'h0000_A000, 33'd96, 12);
        cmd(0);
        tick(1);
        cmd(2);
        wait_state(S_PAU, 10);
        setup(2'd3, 32'h0000_B000, 33'd96, 12);
        pattern_hi = 32'h1234_5678;
        d0 = done_cnt;
        cmd(0);
        check(ch_state == S_ACT, "R2 start from paused", ch_state, S_ACT);
        wait_state(S_IDLE, 40);
        check(beats == 12 && done_cnt == d0 + 1, "R2 reloaded fill", beats, 12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule